// File: doc/BRIEF.md
# Machine-Mode Interrupt Trap Selector

This block decides, every cycle, whether a hart should take an interrupt trap into machine mode and which cause number to report. It combines the pending vector, the enable vector, the delegation mask, the current privilege level and the global machine interrupt enable. The result is a single take flag and a cause code. Nothing inside the block is registered. Any change to its inputs, such as a return instruction that lowers the privilege level or a CSR write to any of the four control inputs, is visible at the outputs in the same cycle.

The seven standard causes it arbitrates are ranked by kind, not by bit index. Within each privilege level, external sources come before software sources, and software sources come before timer sources. Machine sources come before supervisor sources, and the counter-overflow cause is last. Platform causes at bit 16 and above outrank every standard cause, and among themselves the highest index wins. Delivery to lower privilege levels, the trap sequence itself and vectoring belong to other blocks.

Top module: `irq_mtrap_select`

## Requirements
- R1: Bit i can win only if it is set in the pending vector, set in the enable vector and clear in the delegation mask. Clearing either the enable bit or setting the delegation bit removes it.
- R2: The privilege input uses the encoding 2'b11 for machine mode; every other value counts as a lower level. In machine mode an interrupt is taken only while the global enable is 1. At a lower level, eligible interrupts are taken whatever the global enable is.
- R3: Among the standard causes, the highest-priority eligible cause wins, in this order from highest to lowest: 11, 3, 7, 9, 1, 5, 13.
- R4: Any eligible cause at bit index 16 or above wins over every standard cause.
- R5: Among eligible causes at index 16 and above, the one with the highest bit index wins.
- R6: When nothing is eligible, the take flag is 0 and the cause output is 0.
- R7: While the take flag is 1, the cause output equals the bit index of the winning interrupt, zero-extended.
- R8: Standard bits other than the seven ranked ones (0, 2, 4, 6, 8, 10, 12, 14, 15) never produce a take, even when pending, enabled and not delegated.
- R9: The outputs follow input changes within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pend_i | input | VEC_W | Pending interrupt vector, bit i is cause i |
| irq_en_i | input | VEC_W | Interrupt enable vector |
| irq_deleg_i | input | VEC_W | Delegation mask; a set bit routes cause i away from machine mode |
| priv_lvl_i | input | 2 | Current privilege level, 2'b11 is machine mode |
| m_glob_en_i | input | 1 | Global machine interrupt enable |
| take_irq_o | output | 1 | An interrupt trap to machine mode should be taken |
| irq_cause_o | output | CAUSE_W | Cause number of the winning interrupt, 0 when none |

## Verification
A single pending and enabled cause is toggled through its enable and delegation bits, and through machine and lower privilege levels with the global enable on and off. This separates the per-bit qualification from the privilege gate. All seven standard causes are then raised together and removed one at a time from the top, so each step reveals the next rank and would expose any ranking that follows bit index. Mixes of platform bits with standard bits show that platform causes win and that the highest platform index is chosen. Unranked standard bits, both alone and next to a ranked one, show that they are ignored.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam int unsigned STD_N      = 7;
  localparam int unsigned STD_CODE_W = 4;
  localparam int unsigned PLAT_BASE  = 16;

  // Rank 0 is the highest priority among the standard causes.
  function automatic logic [STD_CODE_W-1:0] std_cause_of(input int unsigned rank);
    logic [STD_CODE_W-1:0] code;
    case (rank)
      0:       code = 4'd11;
      1:       code = 4'd3;
      2:       code = 4'd7;
      3:       code = 4'd9;
      4:       code = 4'd1;
      5:       code = 4'd5;
      default: code = 4'd13;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int unsigned VEC_W = 64
) (
  input  logic [VEC_W-1:0] pend_i,
  input  logic [VEC_W-1:0] en_i,
  input  logic [VEC_W-1:0] deleg_i,
  input  logic [1:0]       priv_lvl_i,
  input  logic             m_glob_en_i,
  output logic [VEC_W-1:0] elig_o
);
  import irq_sel_pkg::*;

  logic gate_open;

  always_comb begin
    gate_open = (priv_lvl_i != PRIV_MACHINE) || m_glob_en_i;
  end

  for (genvar gi = 0; gi < VEC_W; gi++) begin : g_bit
    assign elig_o[gi] = pend_i[gi] & en_i[gi] & ~deleg_i[gi] & gate_open;
  end

endmodule

// File: rtl/irq_rank_arb.sv
module irq_rank_arb #(
  parameter int unsigned N      = 7,
  parameter int unsigned RANK_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      req_i,
  output logic              hit_o,
  output logic [RANK_W-1:0] rank_o
);

  always_comb begin
    hit_o  = 1'b0;
    rank_o = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (req_i[r]) begin
        hit_o  = 1'b1;
        rank_o = RANK_W'(r);
      end
    end
  end

endmodule

// File: rtl/irq_plat_arb.sv
module irq_plat_arb #(
  parameter int unsigned VEC_W   = 64,
  parameter int unsigned CAUSE_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0]   elig_i,
  output logic               hit_o,
  output logic [CAUSE_W-1:0] cause_o
);
  import irq_sel_pkg::*;

  if (VEC_W > PLAT_BASE) begin : g_plat
    always_comb begin
      hit_o   = 1'b0;
      cause_o = '0;
      for (int i = PLAT_BASE; i < VEC_W; i++) begin
        if (elig_i[i]) begin
          hit_o   = 1'b1;
          cause_o = CAUSE_W'(i);
        end
      end
    end
  end else begin : g_none
    assign hit_o   = 1'b0;
    assign cause_o = '0;
  end

endmodule

// File: rtl/irq_mtrap_select.sv
module irq_mtrap_select #(
  parameter int unsigned VEC_W   = 64,
  parameter int unsigned CAUSE_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0]   irq_pend_i,
  input  logic [VEC_W-1:0]   irq_en_i,
  input  logic [VEC_W-1:0]   irq_deleg_i,
  input  logic [1:0]         priv_lvl_i,
  input  logic               m_glob_en_i,
  output logic               take_irq_o,
  output logic [CAUSE_W-1:0] irq_cause_o
);
  import irq_sel_pkg::*;

  localparam int unsigned RANK_W = $clog2(STD_N);

  logic [VEC_W-1:0]   elig_vec;
  logic [STD_N-1:0]   std_req;
  logic               std_hit;
  logic [RANK_W-1:0]  std_rank;
  logic               plat_hit;
  logic [CAUSE_W-1:0] plat_cause;
  logic [CAUSE_W-1:0] std_cause;

  irq_qualify #(.VEC_W(VEC_W)) u_qualify (
    .pend_i      (irq_pend_i),
    .en_i        (irq_en_i),
    .deleg_i     (irq_deleg_i),
    .priv_lvl_i  (priv_lvl_i),
    .m_glob_en_i (m_glob_en_i),
    .elig_o      (elig_vec)
  );

  // Gather the ranked standard causes, highest priority at index 0.
  for (genvar gr = 0; gr < STD_N; gr++) begin : g_std
    assign std_req[gr] = elig_vec[std_cause_of(gr)];
  end

  irq_rank_arb #(.N(STD_N), .RANK_W(RANK_W)) u_std_arb (
    .req_i  (std_req),
    .hit_o  (std_hit),
    .rank_o (std_rank)
  );

  irq_plat_arb #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_plat_arb (
    .elig_i  (elig_vec),
    .hit_o   (plat_hit),
    .cause_o (plat_cause)
  );

  always_comb begin
    std_cause = {{(CAUSE_W-STD_CODE_W){1'b0}}, std_cause_of(32'(std_rank))};
  end

  always_comb begin
    take_irq_o  = plat_hit | std_hit;
    irq_cause_o = '0;
    if (plat_hit) begin
      irq_cause_o = plat_cause;
    end else if (std_hit) begin
      irq_cause_o = std_cause;
    end
  end

  // Checks on the combined result against the qualifier and the inputs.
  always_comb begin
    p_winner_eligible_r1: assert (!take_irq_o || elig_vec[irq_cause_o])
      else $error("taken cause is not eligible");
    p_mmode_gate_r2: assert (!((priv_lvl_i == PRIV_MACHINE) && !m_glob_en_i && take_irq_o))
      else $error("take while machine mode is globally disabled");
    p_plat_wins_r4: assert (!plat_hit || (32'(irq_cause_o) >= PLAT_BASE))
      else $error("standard cause chosen over a platform cause");
    p_idle_zero_r6: assert (take_irq_o || (irq_cause_o == '0))
      else $error("cause not zero while idle");
    p_ranked_only_r8: assert (!take_irq_o || (32'(irq_cause_o) >= PLAT_BASE) ||
                              (irq_cause_o == CAUSE_W'(11)) || (irq_cause_o == CAUSE_W'(3)) ||
                              (irq_cause_o == CAUSE_W'(7))  || (irq_cause_o == CAUSE_W'(9)) ||
                              (irq_cause_o == CAUSE_W'(1))  || (irq_cause_o == CAUSE_W'(5)) ||
                              (irq_cause_o == CAUSE_W'(13)))
      else $error("unranked standard cause reported");
  end

endmodule

// File: tb/irq_mtrap_select_bench.sv
module irq_mtrap_select_bench;

  localparam int unsigned VEC_W   = 64;
  localparam int unsigned CAUSE_W = 6;

  logic               clk;
  logic               rst_n;
  logic [VEC_W-1:0]   pend;
  logic [VEC_W-1:0]   en;
  logic [VEC_W-1:0]   deleg;
  logic [1:0]         priv;
  logic               mie;
  logic               take;
  logic [CAUSE_W-1:0] cause;

  int checks;
  int fails;
  int cycles;
  bit done;

  irq_mtrap_select #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_irq_mtrap_select (
    .irq_pend_i  (pend),
    .irq_en_i    (en),
    .irq_deleg_i (deleg),
    .priv_lvl_i  (priv),
    .m_glob_en_i (mie),
    .take_irq_o  (take),
    .irq_cause_o (cause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual cycles=%0d expected <=20000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic expect_out(input string req, input logic exp_take, input int exp_cause);
    #2;
    checks++;
    if (take !== exp_take || cause !== CAUSE_W'(exp_cause)) begin
      fails++;
      $display("FAIL %s: actual take=%0b cause=%0d expected take=%0b cause=%0d",
               req, take, cause, exp_take, exp_cause);
    end
  endtask

  task automatic drive(input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] e,
                       input logic [VEC_W-1:0] d, input logic [1:0] pl, input logic g);
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pl; mie = g;
  endtask

  task automatic t_reset_idle();
    expect_out("R6 idle after reset", 1'b0, 0);
  endtask

  task automatic t_qualify();
    logic [VEC_W-1:0] b7 = VEC_W'(1) << 7;
    drive(b7, b7, '0, 2'b01, 1'b0);
    expect_out("R1 R7 single timer cause", 1'b1, 7);
    drive(b7, '0, '0, 2'b01, 1'b0);
    expect_out("R1 enable cleared", 1'b0, 0);
    drive(b7, b7, b7, 2'b01, 1'b0);
    expect_out("R1 delegated", 1'b0, 0);
  endtask

  task automatic t_priv_gate();
    logic [VEC_W-1:0] b11 = VEC_W'(1) << 11;
    drive(b11, b11, '0, 2'b11, 1'b0);
    expect_out("R2 machine mode, global off", 1'b0, 0);
    drive(b11, b11, '0, 2'b11, 1'b1);
    expect_out("R2 machine mode, global on", 1'b1, 11);
    drive(b11, b11, '0, 2'b00, 1'b0);
    expect_out("R2 user mode, global off", 1'b1, 11);
    drive(b11, b11, '0, 2'b10, 1'b0);
    expect_out("R2 reserved level counts as lower", 1'b1, 11);
  endtask

  task automatic t_std_order();
    int order [7] = '{11, 3, 7, 9, 1, 5, 13};
    logic [VEC_W-1:0] all = '0;
    for (int k = 0; k < 7; k++) all[order[k]] = 1'b1;
    for (int k = 0; k < 7; k++) begin
      drive(all, all, '0, 2'b11, 1'b1);
      expect_out("R3 R7 standard rank", 1'b1, order[k]);
      all[order[k]] = 1'b0;
    end
    drive(all, '1, '0, 2'b11, 1'b1);
    expect_out("R6 all ranked causes removed", 1'b0, 0);
  endtask

  task automatic t_platform();
    logic [VEC_W-1:0] v = '0;
    v[11] = 1'b1; v[3] = 1'b1; v[16] = 1'b1;
    drive(v, v, '0, 2'b01, 1'b0);
    expect_out("R4 platform beats standard", 1'b1, 16);
    v[40] = 1'b1;
    drive(v, v, '0, 2'b01, 1'b0);
    expect_out("R5 higher platform index", 1'b1, 40);
    v[63] = 1'b1;
    drive(v, v, '0, 2'b01, 1'b0);
    expect_out("R5 top platform bit", 1'b1, 63);
    drive(v, v, (VEC_W'(1) << 63) | (VEC_W'(1) << 40) | (VEC_W'(1) << 16), 2'b01, 1'b0);
    expect_out("R4 R1 platform delegated falls back", 1'b1, 11);
  endtask

  task automatic t_unranked();
    logic [VEC_W-1:0] v = '0;
    v[0] = 1'b1; v[2] = 1'b1; v[4] = 1'b1; v[6] = 1'b1; v[8] = 1'b1;
    v[10] = 1'b1; v[12] = 1'b1; v[14] = 1'b1; v[15] = 1'b1;
    drive(v, v, '0, 2'b11, 1'b1);
    expect_out("R8 unranked bits ignored", 1'b0, 0);
    v[5] = 1'b1;
    drive(v, v, '0, 2'b11, 1'b1);
    expect_out("R8 ranked cause beside unranked", 1'b1, 5);
  endtask

  task automatic t_same_cycle();
    logic [VEC_W-1:0] b9 = VEC_W'(1) << 9;
    drive(b9, b9, '0, 2'b11, 1'b0);
    expect_out("R9 gated before enable", 1'b0, 0);
    // Change the global enable between clock edges and sample before the next edge.
    @(posedge clk);
    #3 mie = 1'b1;
    expect_out("R9 follows enable without an edge", 1'b1, 9);
    #3 priv = 2'b11; mie = 1'b0;
    expect_out("R9 follows disable without an edge", 1'b0, 0);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    pend = '0; en = '0; deleg = '0; priv = 2'b11; mie = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_qualify();
    t_priv_gate();
    t_std_order();
    t_platform();
    t_unranked();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule